// File: doc/BRIEF.md
# Multi-Lane Pixel Serializer with Odd Parity

This block takes a 27-bit pixel word from a parallel video source on each pixel clock and turns it into a serial frame for a narrow differential link. The capture edge of the pixel clock is chosen by an input, so the source may launch data on either edge. Each frame holds thirty bit slots: an odd-parity bit, the payload from its top bit down, and two reserved slots that are always zero.

The frame leaves on one, two or three data lanes, next to a forwarded clock lane that is high for the first half of each lane's slots. A supplied bit clock drives the shift registers, and a load strobe from the surrounding clocking logic, one bit clock wide and once per pixel period, starts each frame. With more lanes each lane carries fewer slots, so the bit clock can run proportionally slower. A swap input reverses the physical order of the four lane outputs so that board routing can be kept short. The forbidden lane code parks every lane at zero and raises an error flag.

Top module: `pixel_lane_serializer`

## Requirements
- R1: With `capRise` high the pixel word is taken on the rising edge of `pixClk`. With it low the word is taken on the falling edge. A value present only at the other edge never reaches the lanes.
- R2: With `laneSel` = 00 the frame goes out on data lane 0 over 30 slots. The order is the parity bit, then payload bits 26 down to 0, then two reserved zeros. Data lanes 1 and 2 stay 0.
- R3: The parity slot is 1 when the payload holds an even number of ones and 0 when the count is odd, so the parity bit and the payload together always hold an odd number of ones.
- R4: With `laneSel` = 01 each pixel uses 15 slots per lane. Lane 0 carries frame slots 0 to 14 and lane 1 carries slots 15 to 29. Data lane 2 stays 0.
- R5: With `laneSel` = 10 each pixel uses 10 slots per lane. Lane 0 carries frame slots 0 to 9, lane 1 carries slots 10 to 19 and lane 2 carries slots 20 to 29.
- R6: After a load the forwarded clock lane is 1 for the first floor(S/2) slots and 0 for the rest, where S is the number of slots per lane (30, 15 or 10).
- R7: With `swapLanes` low, `laneOut[3:0]` = {D2, D1, CLK, D0}. With it high, `laneOut[3:0]` = {D0, CLK, D1, D2}.
- R8: With `laneSel` = 11, one bit clock later `errFlag` is 1 and all of `laneOut` is 0. This holds even in the middle of a frame, and load strobes are ignored for as long as the code stays.
- R9: Once the last slot of a frame has gone out and no new load has come, every lane, including the clock lane, outputs 0.
- R10: While `rst_n` is low, `laneOut` and `errFlag` are 0.
- R11: Slot 0 of a frame appears on the lanes right after the bit clock rising edge that samples `loadStb` high, and each later rising edge advances the frame by one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit-rate clock for the shift registers and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixClk | input | 1 | Pixel clock for capturing the parallel word |
| pixData | input | 27 | Parallel pixel payload |
| capRise | input | 1 | 1: capture on the rising edge of pixClk, 0: capture on the falling edge |
| laneSel | input | 2 | Lane count: 00 one lane, 01 two lanes, 10 three lanes, 11 forbidden |
| swapLanes | input | 1 | Reverses the physical order of the lane outputs |
| loadStb | input | 1 | One bit clock wide; starts a new frame |
| laneOut | output | 4 | Physical lane outputs, ordered as in R7 |
| errFlag | output | 1 | Set while the forbidden lane code is selected |

## Verification
A wrong capture register or parity term shows up in slot 0 on the first frame after the load. A wrong lane slice or a bad mask for an unused lane shows up within one pixel period, as a bit in the wrong slot or on the wrong lane. A clock-pattern shift register left loaded with the wrong length shows up in the middle slot, where the forwarded clock falls. Failing to clear on the forbidden code or at the end of a frame leaves stray ones on `laneOut` in the bit clock right after the event. The bench compares every slot of every frame, so each of these faults is reported in the cycle it appears.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;
  localparam int PAY_W     = 27;
  localparam int RES_W     = 2;
  localparam int FRAME_W   = PAY_W + RES_W + 1;
  localparam int MAX_LANES = 3;
  localparam int CNT_W     = $clog2(MAX_LANES + 1);

  typedef struct packed {
    logic             load;
    logic             idle;
    logic [CNT_W-1:0] laneCnt;
  } ctl_t;

  function automatic int slotsPer(input logic [CNT_W-1:0] n);
    if (n == '0) return FRAME_W;
    return FRAME_W / int'(n);
  endfunction
endpackage

// File: rtl/pls_ctrl.sv
`timescale 1ns/1ps
module pls_ctrl
  import pls_pkg::*;
(
  input  logic       bitClk,
  input  logic       rst_n,
  input  logic [1:0] laneSel,
  input  logic       loadStb,
  output ctl_t       ctl,
  output logic       errFlag
);
  logic             badCode;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    badCode = 1'b0;
    cnt     = '0;
    case (laneSel)
      2'b00:   cnt = CNT_W'(1);
      2'b01:   cnt = CNT_W'(2);
      2'b10:   cnt = CNT_W'(3);
      default: badCode = 1'b1;
    endcase
    ctl.idle    = badCode;
    ctl.load    = loadStb & ~badCode;
    ctl.laneCnt = cnt;
  end

  always_ff @(posedge bitClk or negedge rst_n) begin
    if (!rst_n) errFlag <= 1'b0;
    else        errFlag <= badCode;
  end

  // a load is never issued while the forbidden code holds (R8)
  p_no_load_when_idle_r8: assert property (@(posedge bitClk) disable iff (!rst_n)
    (laneSel == 2'b11) |-> !ctl.load);
endmodule

// File: rtl/pls_datapath.sv
`timescale 1ns/1ps
module pls_datapath
  import pls_pkg::*;
(
  input  logic                 bitClk,
  input  logic                 rst_n,
  input  logic                 pixClk,
  input  logic [PAY_W-1:0]     pixData,
  input  logic                 capRise,
  input  ctl_t                 ctl,
  output logic [MAX_LANES-1:0] dataBit,
  output logic                 clkBit
);
  logic [PAY_W-1:0]   capR, capF, pixWord;
  logic [FRAME_W-1:0] frameWord, laneMask, clkPat, clkReg;
  logic [FRAME_W-1:0] shReg [MAX_LANES];
  int                 slotCount;

  always_ff @(posedge pixClk or negedge rst_n) begin
    if (!rst_n) capR <= '0;
    else        capR <= pixData;
  end

  always_ff @(negedge pixClk or negedge rst_n) begin
    if (!rst_n) capF <= '0;
    else        capF <= pixData;
  end

  always_comb begin
    pixWord   = capRise ? capR : capF;
    frameWord = {~^pixWord, pixWord, {RES_W{1'b0}}};
    slotCount = slotsPer(ctl.laneCnt);
    laneMask  = {FRAME_W{1'b1}} << (FRAME_W - slotCount);
    clkPat    = {FRAME_W{1'b1}} << (FRAME_W - slotCount / 2);
  end

  for (genvar l = 0; l < MAX_LANES; l++) begin : g_lane
    always_ff @(posedge bitClk or negedge rst_n) begin
      if (!rst_n)         shReg[l] <= '0;
      else if (ctl.idle)  shReg[l] <= '0;
      else if (ctl.load)  shReg[l] <= (l < int'(ctl.laneCnt)) ?
                                      ((frameWord << (l * slotCount)) & laneMask) : '0;
      else                shReg[l] <= shReg[l] << 1;
    end
    assign dataBit[l] = shReg[l][FRAME_W-1];
  end

  always_ff @(posedge bitClk or negedge rst_n) begin
    if (!rst_n)        clkReg <= '0;
    else if (ctl.idle) clkReg <= '0;
    else if (ctl.load) clkReg <= clkPat;
    else               clkReg <= clkReg << 1;
  end
  assign clkBit = clkReg[FRAME_W-1];

  // the whole loaded frame carries odd weight (R3)
  p_parity_odd_r3: assert property (@(posedge bitClk) disable iff (!rst_n)
    ctl.load |=> ($countones({shReg[0], shReg[1], shReg[2]}) % 2 == 1));

  // single-lane mode leaves the upper data lanes empty (R2)
  p_single_quiet_r2: assert property (@(posedge bitClk) disable iff (!rst_n)
    (ctl.load && ctl.laneCnt == CNT_W'(1)) |=> (shReg[1] == '0 && shReg[2] == '0));

  // forwarded clock starts high in slot 0 (R6)
  p_clk_first_high_r6: assert property (@(posedge bitClk) disable iff (!rst_n)
    ctl.load |=> clkBit);

  // the forbidden code empties every lane on the next edge (R8)
  p_idle_clear_r8: assert property (@(posedge bitClk) disable iff (!rst_n)
    ctl.idle |=> (dataBit == '0 && !clkBit));
endmodule

// File: rtl/pixel_lane_serializer.sv
`timescale 1ns/1ps
module pixel_lane_serializer
  import pls_pkg::*;
(
  input  logic             bitClk,
  input  logic             rst_n,
  input  logic             pixClk,
  input  logic [PAY_W-1:0] pixData,
  input  logic             capRise,
  input  logic [1:0]       laneSel,
  input  logic             swapLanes,
  input  logic             loadStb,
  output logic [3:0]       laneOut,
  output logic             errFlag
);
  ctl_t                 ctl;
  logic [MAX_LANES-1:0] dataBit;
  logic                 clkBit;

  pls_ctrl u_ctrl (
    .bitClk (bitClk),
    .rst_n  (rst_n),
    .laneSel(laneSel),
    .loadStb(loadStb),
    .ctl    (ctl),
    .errFlag(errFlag)
  );

  pls_datapath u_dp (
    .bitClk (bitClk),
    .rst_n  (rst_n),
    .pixClk (pixClk),
    .pixData(pixData),
    .capRise(capRise),
    .ctl    (ctl),
    .dataBit(dataBit),
    .clkBit (clkBit)
  );

  always_comb begin
    if (swapLanes) laneOut = {dataBit[0], clkBit, dataBit[1], dataBit[2]};
    else           laneOut = {dataBit[2], dataBit[1], clkBit, dataBit[0]};
  end

  // error flag and live lanes never coexist (R8)
  p_err_quiet_r8: assert property (@(posedge bitClk) disable iff (!rst_n)
    errFlag |-> (laneOut == 4'b0000));
endmodule

// File: tb/pixel_lane_serializer_tb_top.sv
`timescale 1ns/1ps
module pixel_lane_serializer_tb_top;
  logic        bitClk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pixClk = 1'b0;
  logic [26:0] pixData = '0;
  logic        capRise = 1'b1;
  logic [1:0]  laneSel = 2'b00;
  logic        swapLanes = 1'b0;
  logic        loadStb = 1'b0;
  logic [3:0]  laneOut;
  logic        errFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pixel_lane_serializer dut_i (
    .bitClk(bitClk), .rst_n(rst_n), .pixClk(pixClk), .pixData(pixData),
    .capRise(capRise), .laneSel(laneSel), .swapLanes(swapLanes),
    .loadStb(loadStb), .laneOut(laneOut), .errFlag(errFlag)
  );

  always #2 bitClk = ~bitClk;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int slotsFor(input logic [1:0] sel);
    return (sel == 2'b00) ? 30 : (sel == 2'b01) ? 15 : 10;
  endfunction

  function automatic logic [3:0] expOut(input logic [26:0] d, input logic [1:0] sel,
                                        input int j, input logic sw);
    logic [29:0] fr;
    logic [2:0]  b;
    logic        c;
    int          s;
    int          n;
    fr = {~^d, d, 2'b00};
    s  = slotsFor(sel);
    n  = 30 / s;
    for (int l = 0; l < 3; l++) b[l] = (l < n) ? fr[29 - (l * s + j)] : 1'b0;
    c = (j < s / 2);
    return sw ? {b[0], c, b[1], b[2]} : {b[2], b[1], c, b[0]};
  endfunction

  // capture d on the selected edge, present decoy at the opposite edge, then load
  task automatic runPixel(input logic [26:0] d, input logic [26:0] decoy,
                          input logic [1:0] sel, input logic pol, input logic sw);
    string tag;
    int    s;
    s = slotsFor(sel);
    tag = (sel == 2'b00) ? "R2" : (sel == 2'b01) ? "R4" : "R5";
    if (sw)   tag = {tag, " R7"};
    if (!pol) tag = {tag, " R1"};
    @(negedge bitClk);
    laneSel = sel; swapLanes = sw; capRise = pol;
    pixClk = ~pol;
    pixData = d;
    #0.3 pixClk = pol;
    #0.3 pixData = decoy;
    #0.3 pixClk = ~pol;
    #0.3 loadStb = 1'b1;
    @(negedge bitClk);
    loadStb = 1'b0;
    for (int j = 0; j < s; j++) begin
      chk((j == 0) ? {tag, " R3 R11 R6"} : {tag, " R6"}, laneOut, expOut(d, sel, j, sw));
      @(negedge bitClk);
    end
    chk("R9 drained", laneOut, 4'b0000);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge bitClk);
    chk("R10 reset lanes", laneOut, 4'b0000);
    chk("R10 reset flag", {3'b000, errFlag}, 4'b0000);
    rst_n = 1'b1;
    @(negedge bitClk);
    chk("R10 after reset", {errFlag, laneOut[2:0]}, 4'b0000);

    // directed corners
    runPixel(27'h0000000, 27'h7FFFFFF, 2'b00, 1'b1, 1'b0);
    runPixel(27'h7FFFFFF, 27'h0000000, 2'b00, 1'b0, 1'b0);
    runPixel(27'h4000000, 27'h0000001, 2'b01, 1'b1, 1'b1);
    runPixel(27'h0000001, 27'h4000000, 2'b10, 1'b0, 1'b1);
    runPixel(27'h2AAAAAA, 27'h5555555, 2'b10, 1'b1, 1'b0);

    // forbidden code mid-frame and with load strobes
    @(negedge bitClk);
    laneSel = 2'b00; swapLanes = 1'b0; capRise = 1'b1;
    pixClk = 1'b0; pixData = 27'h7FFFFFF;
    #0.3 pixClk = 1'b1;
    #0.3 loadStb = 1'b1;
    @(negedge bitClk);
    loadStb = 1'b0;
    repeat (3) @(negedge bitClk);
    laneSel = 2'b11;
    loadStb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge bitClk);
      chk("R8 lanes idle", laneOut, 4'b0000);
      chk("R8 flag", {3'b000, errFlag}, 4'b0001);
    end
    loadStb = 1'b0;
    laneSel = 2'b00;
    @(negedge bitClk);
    chk("R8 flag clears", {3'b000, errFlag}, 4'b0000);
    chk("R8 no stray frame", laneOut, 4'b0000);

    // constrained random
    for (int i = 0; i < 45; i++) begin
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 2));
      runPixel(27'($urandom), 27'($urandom), sel, 1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule